// File: doc/BRIEF.md
# Register-Amount Shifter with Carry

This block shifts or rotates a 32-bit operand by an amount held in a register. It supports four operations: logical left shift, logical right shift, arithmetic right shift and rotate right. The amount comes from the low byte of a 32-bit amount input, so it can be any value from 0 to 255. Each operation has its own rule for the carry-out at an amount of zero, at exactly 32 and above 32, and the block applies these rules exactly.

An execution pipeline presents the operation, the operand, the amount and the incoming carry flag, and raises `in_valid`. On the next clock edge the block registers the result and carry-out and raises `out_valid` for one cycle. When `in_valid` is low, both registered outputs keep their last values.

Top module: `barrel_shift_unit`

## Requirements
- R1: Only `amount[7:0]` is used. Bits 31..8 have no effect on the result or the carry.
- R2: For every operation, an amount of 0 returns the operand unchanged and copies `carry_in` to `carry_out`.
- R3: With `shift_kind` = 2'b00 (logical left) and amount n from 1 to 31, the result is the operand shifted left by n with zeros filled in, and the carry is operand bit (32 − n).
- R4: For a logical left shift by exactly 32, the result is 0 and the carry is operand bit 0. Above 32, the result and the carry are both 0.
- R5: With `shift_kind` = 2'b01 (logical right) and n from 1 to 31, the result is the operand shifted right by n with zeros filled in, and the carry is operand bit (n − 1).
- R6: For a logical right shift by exactly 32, the result is 0 and the carry is operand bit 31. Above 32, the result and the carry are both 0.
- R7: With `shift_kind` = 2'b10 (arithmetic right), n from 1 to 31 fills with bit 31 and gives carry = operand bit (n − 1). For n of 32 or more, every result bit and the carry equal operand bit 31.
- R8: With `shift_kind` = 2'b11 (rotate right), let r = n mod 32. For r ≠ 0, the result is the operand rotated right by r and the carry is operand bit (r − 1).
- R9: For a rotate right where n ≠ 0 and n mod 32 = 0, the result is the operand unchanged and the carry is operand bit 31.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and `carry_out` update only on such a transfer and otherwise hold. After reset, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| shift_kind | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| operand | input | 32 | Value to shift |
| amount | input | 32 | Shift amount register; low byte used |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Registered shifted value |
| carry_out | output | 1 | Registered carry-out |

## Verification
Every operation is driven at the amounts that split the rules: 0, 1, 31, 32, 33, 64, 255, and words whose upper bytes are set on top of these low bytes. The operands are chosen so that the carry bit differs from its neighbours: a lone 1, an alternating pattern, and a negative value. This way an off-by-one carry index or a wrong fill bit shows up as a wrong value. Random mixes of operation, amount and valid gaps then check the hold behaviour. The reference model performs n single-bit steps instead of one shift of width n, so its carry rules at 32 and above come out of the stepping and are not restated.

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   shift_kind,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] amount,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         carry_out
);
  localparam int LW = $clog2(W);

  logic [7:0]    amt;
  logic [LW-1:0] low;
  logic          zero_amt, exact_w, over_w;
  logic [LW-1:0] lsl_idx, rsh_idx;
  logic [W-1:0]  ror_val, nxt_val;
  logic          nxt_c;
  logic [W-9:0]  unused_hi;

  assign amt       = amount[7:0];
  assign unused_hi = amount[W-1:8];
  assign low       = amt[LW-1:0];
  assign zero_amt  = (amt == 8'd0);
  assign exact_w   = (amt == 8'(W));
  assign over_w    = (amt > 8'(W));
  assign lsl_idx   = LW'(W - int'(low));
  assign rsh_idx   = low - LW'(1);
  assign ror_val   = (operand >> low) | (operand << (LW+1)'(W - int'(low)));

  always_comb begin
    nxt_val = operand;
    nxt_c   = carry_in;
    if (!zero_amt) begin
      unique case (shift_kind)
        2'b00: begin
          if (exact_w)     begin nxt_val = '0; nxt_c = operand[0]; end
          else if (over_w) begin nxt_val = '0; nxt_c = 1'b0; end
          else             begin nxt_val = operand << low; nxt_c = operand[lsl_idx]; end
        end
        2'b01: begin
          if (exact_w)     begin nxt_val = '0; nxt_c = operand[W-1]; end
          else if (over_w) begin nxt_val = '0; nxt_c = 1'b0; end
          else             begin nxt_val = operand >> low; nxt_c = operand[rsh_idx]; end
        end
        2'b10: begin
          if (exact_w || over_w) begin
            nxt_val = {W{operand[W-1]}};
            nxt_c   = operand[W-1];
          end else begin
            nxt_val = W'($signed(operand) >>> low);
            nxt_c   = operand[rsh_idx];
          end
        end
        default: begin
          if (low == '0) begin nxt_val = operand; nxt_c = operand[W-1]; end
          else           begin nxt_val = ror_val; nxt_c = operand[rsh_idx]; end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_val;
        carry_out <= nxt_c;
      end
    end
  end
endmodule

// File: rtl/barrel_shift_unit_checks.sv
module barrel_shift_unit_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   shift_kind,
  input logic [W-1:0] operand,
  input logic [W-1:0] amount,
  input logic         carry_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         carry_out
);
  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(carry_out));
  p_zero_amt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && amount[7:0] == 8'd0) |=>
      (result == $past(operand) && carry_out == $past(carry_in)));
  p_lsl_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_kind == 2'b00 && amount[7:0] > 8'(W)) |=>
      (result == '0 && !carry_out));
  p_lsr_over_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_kind == 2'b01 && amount[7:0] > 8'(W)) |=>
      (result == '0 && !carry_out));
  p_asr_big_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_kind == 2'b10 && amount[7:0] >= 8'(W)) |=>
      (result == {W{$past(operand[W-1])}} && carry_out == $past(operand[W-1])));
  p_ror_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_kind == 2'b11 && amount[7:0] != 8'd0 && amount[4:0] == 5'd0) |=>
      (result == $past(operand) && carry_out == $past(operand[W-1])));
endmodule

bind barrel_shift_unit barrel_shift_unit_checks #(.W(W)) u_checks (.*);

// File: tb/tb_barrel_shift_unit.sv
module tb_barrel_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  shift_kind = 2'b00;
  logic [31:0] operand = '0;
  logic [31:0] amount = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;

  barrel_shift_unit dut (.*);

  always #4 clk = ~clk;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_v = 1'b0;
  logic [31:0] exp_r = '0;
  bit exp_c = 1'b0;
  string exp_tag = "R10";

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R10 watchdog expired: got %0d cycles, expected fewer than 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic string tag_of(logic [1:0] k, logic [31:0] a);
    int n = int'(a[7:0]);
    if (a[31:8] != 0) return "R1";
    if (n == 0) return "R2";
    case (k)
      2'b00: return (n < 32) ? "R3" : "R4";
      2'b01: return (n < 32) ? "R5" : "R6";
      2'b10: return "R7";
      default: return (n % 32 == 0) ? "R9" : "R8";
    endcase
  endfunction

  task automatic model(input logic [1:0] k, input logic [31:0] d, input logic [31:0] a,
                       input bit ci, output logic [31:0] r, output bit c);
    int n = int'(a[7:0]);
    r = d;
    c = ci;
    for (int i = 0; i < n; i++) begin
      case (k)
        2'b00: begin c = r[31]; r = {r[30:0], 1'b0}; end
        2'b01: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin r = {r[0], r[31:1]}; c = r[31]; end
      endcase
    end
  endtask

  task automatic compare();
    vectors++;
    if (out_valid !== exp_v || result !== exp_r || carry_out !== exp_c) begin
      errors++;
      $display("FAIL %s: got v=%0b r=%h c=%0b, expected v=%0b r=%h c=%0b",
               exp_tag, out_valid, result, carry_out, exp_v, exp_r, exp_c);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] k, input logic [31:0] d,
                      input logic [31:0] a, input bit ci);
    logic [31:0] r;
    bit c;
    in_valid = v; shift_kind = k; operand = d; amount = a; carry_in = ci;
    exp_v = v;
    if (v) begin
      model(k, d, a, ci, r, c);
      exp_r = r; exp_c = c;
      exp_tag = tag_of(k, a);
    end else begin
      exp_tag = "R10";
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    logic [31:0] pats [4] = '{32'h0000_0001, 32'hA5A5_5A5A, 32'h8000_0001, 32'hFFFF_FFFE};
    int amts [10] = '{0, 1, 2, 16, 31, 32, 33, 64, 96, 255};
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 4; p++)
        for (int a = 0; a < 10; a++) begin
          step(1'b1, 2'(k), pats[p], 32'(amts[a]), 1'(a + p));
          step(1'b1, 2'(k), pats[p], 32'(amts[a]) | 32'hDEAD_0000 | 32'(p << 8) | 32'h100, 1'(a));
        end
    step(1'b0, 2'b11, 32'h1234_5678, 32'd4, 1'b1);
    step(1'b0, 2'b00, 32'hFFFF_FFFF, 32'd0, 1'b0);
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 3) != 0), 2'($urandom), $urandom, 32'($urandom), 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule